// File: doc/BRIEF.md
# Helper-Thread Spawn and Kill Controller

This block sits beside a cluster of processors that run one user thread split into speculative threads, each with a rank in a total speculation order. When the most speculative thread misses in the second-level cache on a load whose value can be predicted, and the address has a good prediction record, the block asks for that thread to be copied onto a free processor. The copy runs ahead only to warm the caches. The block tracks every helper it creates and its parent. It issues a kill as soon as the helper is no longer useful or no longer safe.

While a processor holds a helper, squashes aimed at it and squashes it would start are masked. Its finish signal is not passed on toward commit. The block also holds a small table of 2-bit confidence counters, trained by value-prediction outcomes and indexed by a hash of the miss address. The register-state copy, the value predictor, the caches and commit arbitration are outside this block.

Top module: `helper_spawn_ctrl`

## Requirements
- R1: A clone request (`clone_valid_o`, with `clone_ra_o` = 1) appears one cycle after a miss only if `miss_valid_i` and `miss_pred_i` are both high and the missing processor is the most speculative one. When `clone_valid_o` is low, `clone_ra_o` is low.
- R2: Each confidence entry is a 2-bit counter that resets to 0. It rises by one, saturating at 3, on a correct update and returns to 0 on a wrong one. The entry index is the XOR of all 4-bit slices of the address. A spawn needs the entry for the miss address to read 3 in the miss cycle, before any update made in that same cycle.
- R3: The clone target is the lowest-numbered processor that is neither busy nor holding a live helper. If no processor is free, no clone is issued.
- R4: The most speculative thread is the busy, non-helper processor with the highest `rank_i` field (3 bits per processor, processor p at bits 3p+2..3p). Ties go to the lowest processor number.
- R5: For a processor holding a live helper, `squash_tgt_o` and `squash_src_o` are forced low. For any other processor they copy `squash_tgt_i` and `squash_src_i` in the same cycle.
- R6: A live helper whose parent is no longer the most speculative thread gets its bit in `kill_o` one cycle later, and its processor is free from that cycle on.
- R7: A live helper is killed in the same way when its parent finishes, when it finishes itself, or when it raises an exception.
- R8: A parent has at most one live helper. A qualifying miss from a parent whose helper is alive and not being killed is ignored.
- R9: If a parent's qualifying miss falls in the cycle in which its helper is being killed, the kill goes out first. The clone follows one cycle later than it normally would, provided the parent is still most speculative and a processor is free then.
- R10: `done_o` copies `finish_i` for ordinary threads and is low for processors that hold a live helper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| proc_busy_i | input | NPROC | Processor runs an ordinary speculative thread |
| rank_i | input | NPROC*RANK_W | Speculation rank per processor, higher is more speculative |
| miss_valid_i | input | 1 | Second-level cache miss event |
| miss_proc_i | input | PID_W | Processor that missed |
| miss_addr_i | input | ADDR_W | Missing address |
| miss_pred_i | input | 1 | Loaded value can be predicted |
| conf_upd_valid_i | input | 1 | Prediction outcome for training |
| conf_upd_addr_i | input | ADDR_W | Address of the trained prediction |
| conf_upd_hit_i | input | 1 | Prediction was correct |
| finish_i | input | NPROC | Thread on processor finished |
| except_i | input | NPROC | Thread on processor raised an exception |
| squash_tgt_i | input | NPROC | Squash aimed at processor |
| squash_src_i | input | NPROC | Squash started by processor |
| squash_tgt_o | output | NPROC | Filtered squash targets |
| squash_src_o | output | NPROC | Filtered squash sources |
| done_o | output | NPROC | Finish events forwarded toward commit |
| clone_valid_o | output | 1 | Clone request |
| clone_src_o | output | PID_W | Thread to copy |
| clone_dst_o | output | PID_W | Processor that receives the helper |
| clone_ra_o | output | 1 | Helper runs in run-ahead mode |
| kill_o | output | NPROC | Helpers to tear down |

## Verification
The hardest case to reach is the coincidence of a helper teardown with a fresh qualifying miss from the same parent. It needs a trained confidence entry, a live helper, a parent still at the top of the order and a finish from the helper, all in one cycle. A directed sequence first trains an address to saturation, spawns a helper, then raises the helper's finish together with a new miss from the parent. It then checks the kill and the late clone in consecutive cycles. Random traffic over a small address pool with slowly changing ranks keeps helpers alive long enough to meet every kill cause many times. All of it is compared against a cycle model in the bench.

// File: rtl/hs_pkg.sv
// Shared types for the helper spawn controller: the confidence counter
// type and its update rule. Assumes 2-bit counters.
package hs_pkg;
    typedef logic [1:0] conf_cnt_t;
    localparam conf_cnt_t CONF_TOP = 2'b11;

    // Next counter value: saturating step on a hit, clear on a miss.
    function automatic conf_cnt_t conf_next(input conf_cnt_t c, input logic hit);
        if (!hit)            return '0;
        else if (c == CONF_TOP) return c;
        else                 return c + conf_cnt_t'(1);
    endfunction
endpackage

// File: rtl/hs_conf_table.sv
// Address-indexed confidence table. Lookup is combinational and reads the
// value held before any same-cycle update. Index = XOR fold of all
// IDX_W-bit slices of the address. Assumes one update port.
module hs_conf_table
    import hs_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_conf,
    input  logic              upd_valid,
    input  logic [ADDR_W-1:0] upd_addr,
    input  logic              upd_hit
);
    localparam int DEPTH  = 1 << IDX_W;
    localparam int NCHUNK = (ADDR_W + IDX_W - 1) / IDX_W;
    localparam int PAD_W  = NCHUNK * IDX_W;

    conf_cnt_t tbl [DEPTH];
    logic [IDX_W-1:0] look_idx, upd_idx;

    // Fold an address into a table index.
    function automatic logic [IDX_W-1:0] fold(input logic [ADDR_W-1:0] a);
        logic [PAD_W-1:0] p;
        logic [IDX_W-1:0] r;
        p = PAD_W'(a);
        r = '0;
        for (int k = 0; k < NCHUNK; k++) r ^= p[k*IDX_W +: IDX_W];
        return r;
    endfunction

    assign look_idx  = fold(look_addr);
    assign upd_idx   = fold(upd_addr);
    assign look_conf = (tbl[look_idx] == CONF_TOP);

    // Clear on reset, train one entry per update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) tbl[k] <= '0;
        end else if (upd_valid) begin
            tbl[upd_idx] <= conf_next(tbl[upd_idx], upd_hit);
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_chk
        // R2
        cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (tbl[e] != $past(tbl[e])) |-> (tbl[e] == '0 || tbl[e] == $past(tbl[e]) + conf_cnt_t'(1)))
            else $error("confidence counter jumped");
    end
endmodule

// File: rtl/hs_rank_select.sv
// Picks the most speculative eligible processor: highest rank wins,
// ties go to the lowest index. Purely combinational.
module hs_rank_select #(
    parameter int NPROC  = 4,
    parameter int RANK_W = 3,
    localparam int PID_W = $clog2(NPROC)
) (
    input  logic [NPROC-1:0]        elig,
    input  logic [NPROC*RANK_W-1:0] rank,
    output logic                    top_valid,
    output logic [PID_W-1:0]        top_id
);
    logic [RANK_W-1:0] best;

    // Linear scan with strict compare so the lowest index keeps a tie.
    always_comb begin
        top_valid = 1'b0;
        top_id    = '0;
        best      = '0;
        for (int i = 0; i < NPROC; i++) begin
            if (elig[i] && (!top_valid || rank[i*RANK_W +: RANK_W] > best)) begin
                top_valid = 1'b1;
                top_id    = PID_W'(i);
                best      = rank[i*RANK_W +: RANK_W];
            end
        end
    end
endmodule

// File: rtl/hs_helper_track.sv
// Per-processor helper bookkeeping: live flag and parent id. Evaluates
// the kill causes every cycle and registers the kill mask. Assumes a
// spawn target is never a live helper.
module hs_helper_track #(
    parameter int NPROC  = 4,
    localparam int PID_W = $clog2(NPROC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             spawn_fire,
    input  logic [PID_W-1:0] spawn_src,
    input  logic [PID_W-1:0] spawn_dst,
    input  logic             top_valid,
    input  logic [PID_W-1:0] top_id,
    input  logic [NPROC-1:0] finish_i,
    input  logic [NPROC-1:0] except_i,
    output logic [NPROC-1:0] alive_o,
    output logic [NPROC-1:0] kill_o,
    output logic [NPROC-1:0] has_helper_o,
    output logic [NPROC-1:0] killing_o
);
    logic [NPROC-1:0] alive, kill_now;
    logic [PID_W-1:0] parent [NPROC];
    logic [NPROC-1:0] owned  [NPROC];

    for (genvar h = 0; h < NPROC; h++) begin : g_kill
        // Kill cause for helper h: rank lost, parent or self done, or fault.
        assign kill_now[h] = alive[h] & (!top_valid || top_id != parent[h] ||
                             finish_i[parent[h]] || finish_i[h] || except_i[h]);
    end

    // Group live helpers by parent.
    always_comb begin
        for (int p = 0; p < NPROC; p++) begin
            for (int h = 0; h < NPROC; h++)
                owned[p][h] = alive[h] && (parent[h] == PID_W'(p));
            has_helper_o[p] = |owned[p];
            killing_o[p]    = |(owned[p] & kill_now);
        end
    end

    // Live flags and parents: kills clear, spawns set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alive  <= '0;
            kill_o <= '0;
            for (int h = 0; h < NPROC; h++) parent[h] <= '0;
        end else begin
            kill_o <= kill_now;
            for (int h = 0; h < NPROC; h++) begin
                if (spawn_fire && spawn_dst == PID_W'(h)) begin
                    alive[h]  <= 1'b1;
                    parent[h] <= spawn_src;
                end else if (kill_now[h]) begin
                    alive[h] <= 1'b0;
                end
            end
        end
    end

    assign alive_o = alive;

    for (genvar p = 0; p < NPROC; p++) begin : g_one
        // R8
        one_helper_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(owned[p])) else $error("parent owns two helpers");
    end

    // R6
    kill_was_helper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|kill_o) |-> ((kill_o & ~$past(alive)) == '0))
        else $error("kill issued for a non-helper");
endmodule

// File: rtl/helper_spawn_ctrl.sv
// Helper-thread spawn and kill controller. Decides when the most
// speculative thread is cloned into a run-ahead helper, picks the target
// processor, tracks helpers, issues kills and masks squash/finish events
// of helpers. Assumes proc_busy_i covers ordinary threads only.
module helper_spawn_ctrl
    import hs_pkg::*;
#(
    parameter int NPROC  = 4,
    parameter int RANK_W = 3,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 4,
    localparam int PID_W = $clog2(NPROC)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [NPROC-1:0]        proc_busy_i,
    input  logic [NPROC*RANK_W-1:0] rank_i,
    input  logic                    miss_valid_i,
    input  logic [PID_W-1:0]        miss_proc_i,
    input  logic [ADDR_W-1:0]       miss_addr_i,
    input  logic                    miss_pred_i,
    input  logic                    conf_upd_valid_i,
    input  logic [ADDR_W-1:0]       conf_upd_addr_i,
    input  logic                    conf_upd_hit_i,
    input  logic [NPROC-1:0]        finish_i,
    input  logic [NPROC-1:0]        except_i,
    input  logic [NPROC-1:0]        squash_tgt_i,
    input  logic [NPROC-1:0]        squash_src_i,
    output logic [NPROC-1:0]        squash_tgt_o,
    output logic [NPROC-1:0]        squash_src_o,
    output logic [NPROC-1:0]        done_o,
    output logic                    clone_valid_o,
    output logic [PID_W-1:0]        clone_src_o,
    output logic [PID_W-1:0]        clone_dst_o,
    output logic                    clone_ra_o,
    output logic [NPROC-1:0]        kill_o
);
    logic [NPROC-1:0] alive, has_helper, killing, elig, free;
    logic             top_valid, conf_ok, any_free;
    logic [PID_W-1:0] top_id, free_id, spawn_src;
    logic             miss_ok, pend_go, new_go, defer, spawn_fire;
    logic             pend_valid;
    logic [PID_W-1:0] pend_src;
    logic [NPROC-1:0] dst_onehot;

    assign elig = proc_busy_i & ~alive;
    assign free = ~proc_busy_i & ~alive;

    hs_rank_select #(.NPROC(NPROC), .RANK_W(RANK_W)) u_rank (
        .elig(elig), .rank(rank_i), .top_valid(top_valid), .top_id(top_id)
    );

    hs_conf_table #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_conf (
        .clk(clk), .rst_n(rst_n),
        .look_addr(miss_addr_i), .look_conf(conf_ok),
        .upd_valid(conf_upd_valid_i), .upd_addr(conf_upd_addr_i), .upd_hit(conf_upd_hit_i)
    );

    hs_helper_track #(.NPROC(NPROC)) u_track (
        .clk(clk), .rst_n(rst_n),
        .spawn_fire(spawn_fire), .spawn_src(spawn_src), .spawn_dst(free_id),
        .top_valid(top_valid), .top_id(top_id),
        .finish_i(finish_i), .except_i(except_i),
        .alive_o(alive), .kill_o(kill_o),
        .has_helper_o(has_helper), .killing_o(killing)
    );

    // Lowest-numbered free processor.
    always_comb begin
        free_id = '0;
        for (int k = NPROC - 1; k >= 0; k--)
            if (free[k]) free_id = PID_W'(k);
    end
    assign any_free = |free;

    // Spawn decision: deferred request first, then a fresh qualifying miss.
    always_comb begin
        miss_ok = miss_valid_i && miss_pred_i && conf_ok && top_valid && (top_id == miss_proc_i);
        pend_go = pend_valid && top_valid && (top_id == pend_src) && !has_helper[pend_src] && any_free;
        new_go  = miss_ok && !has_helper[miss_proc_i] && any_free && !pend_go;
        defer   = miss_ok && has_helper[miss_proc_i] && killing[miss_proc_i];
        spawn_fire = pend_go || new_go;
        spawn_src  = pend_go ? pend_src : miss_proc_i;
    end

    // Clone request and deferred-spawn registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clone_valid_o <= 1'b0;
            clone_ra_o    <= 1'b0;
            clone_src_o   <= '0;
            clone_dst_o   <= '0;
            pend_valid    <= 1'b0;
            pend_src      <= '0;
        end else begin
            clone_valid_o <= spawn_fire;
            clone_ra_o    <= spawn_fire;
            clone_src_o   <= spawn_src;
            clone_dst_o   <= free_id;
            pend_valid    <= defer;
            pend_src      <= miss_proc_i;
        end
    end

    // Helpers neither receive nor cause squashes, and never report done.
    assign squash_tgt_o = squash_tgt_i & ~alive;
    assign squash_src_o = squash_src_i & ~alive;
    assign done_o       = finish_i & ~alive;

    assign dst_onehot = NPROC'(1) << clone_dst_o;

    // R3
    clone_dst_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clone_valid_o |-> ((($past(proc_busy_i) | $past(alive)) & dst_onehot) == '0))
        else $error("clone target was not free");

    // R9
    defer_no_clone_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pend_valid |-> !clone_valid_o)
        else $error("clone issued in the kill cycle of a deferred spawn");
endmodule

// File: tb/test_helper_spawn_ctrl.sv
`timescale 1ns/1ps
module test_helper_spawn_ctrl;
    localparam int NP = 4;
    localparam int RW = 3;
    localparam int AW = 32;

    logic clk = 1'b0;
    logic rst_n;
    logic [NP-1:0] proc_busy_i, finish_i, except_i, squash_tgt_i, squash_src_i;
    logic [NP*RW-1:0] rank_i;
    logic miss_valid_i, miss_pred_i, conf_upd_valid_i, conf_upd_hit_i;
    logic [1:0] miss_proc_i;
    logic [AW-1:0] miss_addr_i, conf_upd_addr_i;
    logic [NP-1:0] squash_tgt_o, squash_src_o, done_o, kill_o;
    logic clone_valid_o, clone_ra_o;
    logic [1:0] clone_src_o, clone_dst_o;

    int n_chk = 0, n_bad = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    helper_spawn_ctrl i_helper_spawn_ctrl (
        .clk(clk), .rst_n(rst_n), .proc_busy_i(proc_busy_i), .rank_i(rank_i),
        .miss_valid_i(miss_valid_i), .miss_proc_i(miss_proc_i), .miss_addr_i(miss_addr_i),
        .miss_pred_i(miss_pred_i), .conf_upd_valid_i(conf_upd_valid_i),
        .conf_upd_addr_i(conf_upd_addr_i), .conf_upd_hit_i(conf_upd_hit_i),
        .finish_i(finish_i), .except_i(except_i), .squash_tgt_i(squash_tgt_i),
        .squash_src_i(squash_src_i), .squash_tgt_o(squash_tgt_o), .squash_src_o(squash_src_o),
        .done_o(done_o), .clone_valid_o(clone_valid_o), .clone_src_o(clone_src_o),
        .clone_dst_o(clone_dst_o), .clone_ra_o(clone_ra_o), .kill_o(kill_o)
    );

    // Bench model state
    bit [NP-1:0] m_alive;
    int          m_par [NP];
    int          m_cnt [16];
    bit          m_pend;
    int          m_psrc;
    bit          e_cv;
    int          e_src, e_dst;
    bit [NP-1:0] e_kill;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int fold(input logic [AW-1:0] a);
        int r = 0;
        for (int k = 0; k < 8; k++) r ^= int'(a[k*4 +: 4]);
        return r;
    endfunction

    function automatic int m_top();
        int id = -1;
        int best = -1;
        for (int i = 0; i < NP; i++)
            if (proc_busy_i[i] && !m_alive[i] && int'(rank_i[i*RW +: RW]) > best) begin
                best = int'(rank_i[i*RW +: RW]);
                id = i;
            end
        return id;
    endfunction

    task automatic set_idle();
        miss_valid_i = 0; miss_pred_i = 0; miss_proc_i = 0; miss_addr_i = '0;
        conf_upd_valid_i = 0; conf_upd_hit_i = 0; conf_upd_addr_i = '0;
        finish_i = '0; except_i = '0; squash_tgt_i = '0; squash_src_i = '0;
    endtask

    task automatic set_rank(input int p, input int v);
        rank_i[p*RW +: RW] = RW'(v);
    endtask

    // One cycle: check combinational filters, step the model, check registered outputs.
    task automatic cyc();
        int top, fdst, src;
        bit [NP-1:0] kn, has, kil, free, nal;
        bit hit, mq, pgo, ngo, dfr;
        #1;
        chk(squash_tgt_o == (squash_tgt_i & ~m_alive), "R5 squash_tgt", 32'(squash_tgt_o), 32'(squash_tgt_i & ~m_alive));
        chk(squash_src_o == (squash_src_i & ~m_alive), "R5 squash_src", 32'(squash_src_o), 32'(squash_src_i & ~m_alive));
        chk(done_o == (finish_i & ~m_alive), "R10 done", 32'(done_o), 32'(finish_i & ~m_alive));
        top = m_top();
        kn = '0; has = '0; kil = '0;
        for (int h = 0; h < NP; h++) begin
            if (m_alive[h])
                kn[h] = (top != m_par[h]) || finish_i[m_par[h]] || finish_i[h] || except_i[h];
        end
        for (int h = 0; h < NP; h++) if (m_alive[h]) begin
            has[m_par[h]] = 1;
            if (kn[h]) kil[m_par[h]] = 1;
        end
        hit  = (m_cnt[fold(miss_addr_i)] == 3);
        free = ~proc_busy_i & ~m_alive;
        fdst = 0;
        for (int k = NP - 1; k >= 0; k--) if (free[k]) fdst = k;
        mq  = miss_valid_i && miss_pred_i && hit && top >= 0 && top == int'(miss_proc_i);
        pgo = m_pend && top >= 0 && top == m_psrc && !has[m_psrc] && (free != 0);
        ngo = mq && !has[miss_proc_i] && (free != 0) && !pgo;
        dfr = mq && has[miss_proc_i] && kil[miss_proc_i];
        src = pgo ? m_psrc : int'(miss_proc_i);
        e_cv = pgo || ngo; e_src = src; e_dst = fdst; e_kill = kn;
        nal = m_alive & ~kn;
        if (e_cv) begin nal[fdst] = 1; m_par[fdst] = src; end
        m_alive = nal;
        m_pend = dfr; m_psrc = int'(miss_proc_i);
        if (conf_upd_valid_i) begin
            int ix = fold(conf_upd_addr_i);
            m_cnt[ix] = conf_upd_hit_i ? ((m_cnt[ix] == 3) ? 3 : m_cnt[ix] + 1) : 0;
        end
        @(posedge clk); @(negedge clk);
        chk(clone_valid_o == e_cv, "R1 clone_valid", 32'(clone_valid_o), 32'(e_cv));
        chk(clone_ra_o == e_cv, "R1 clone_ra", 32'(clone_ra_o), 32'(e_cv));
        if (e_cv && clone_valid_o) begin
            chk(int'(clone_src_o) == e_src, "R4 clone_src", 32'(clone_src_o), 32'(e_src));
            chk(int'(clone_dst_o) == e_dst, "R3 clone_dst", 32'(clone_dst_o), 32'(e_dst));
        end
        chk(kill_o == e_kill, "R6 kill", 32'(kill_o), 32'(e_kill));
    endtask

    task automatic miss(input int p, input logic [AW-1:0] a, input bit pred);
        miss_valid_i = 1; miss_proc_i = 2'(p); miss_addr_i = a; miss_pred_i = pred;
    endtask

    task automatic train(input logic [AW-1:0] a, input bit hitv);
        set_idle(); conf_upd_valid_i = 1; conf_upd_addr_i = a; conf_upd_hit_i = hitv; cyc();
    endtask

    localparam logic [AW-1:0] ADDR_A = 32'h0000_0040;

    initial begin
        int pool [4];
        pool[0] = 32'h0000_0040; pool[1] = 32'h0001_2380;
        pool[2] = 32'h00a0_0c00; pool[3] = 32'h7000_0004;
        void'($urandom(32'd4711));
        rst_n = 0; set_idle();
        proc_busy_i = 4'b0011; rank_i = '0;
        set_rank(0, 1); set_rank(1, 5);
        m_alive = '0; m_pend = 0; m_psrc = 0;
        for (int i = 0; i < NP; i++) m_par[i] = 0;
        for (int i = 0; i < 16; i++) m_cnt[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        chk(clone_valid_o == 0, "R1 reset clone", 32'(clone_valid_o), 0);
        chk(kill_o == '0, "R6 reset kill", 32'(kill_o), 0);

        // Untrained address: no clone
        set_idle(); miss(1, ADDR_A, 1); cyc();
        chk(clone_valid_o == 0, "R2 untrained", 32'(clone_valid_o), 0);
        train(ADDR_A, 1); train(ADDR_A, 1); train(ADDR_A, 1); train(ADDR_A, 0);
        set_idle(); miss(1, ADDR_A, 1); cyc();
        chk(clone_valid_o == 0, "R2 reset by wrong", 32'(clone_valid_o), 0);
        train(ADDR_A, 1); train(ADDR_A, 1); train(ADDR_A, 1);
        set_idle(); miss(1, ADDR_A, 0); cyc();
        chk(clone_valid_o == 0, "R1 not predictable", 32'(clone_valid_o), 0);
        set_idle(); miss(0, ADDR_A, 1); cyc();
        chk(clone_valid_o == 0, "R4 not most speculative", 32'(clone_valid_o), 0);
        set_idle(); miss(1, ADDR_A, 1); cyc();
        chk(clone_valid_o && clone_src_o == 1 && clone_dst_o == 2, "R1 spawn",
            {clone_valid_o, 2'b0, clone_src_o, 2'b0, clone_dst_o}, 32'h112);
        set_idle(); squash_tgt_i = 4'b1111; squash_src_i = 4'b1111; #1;
        chk(squash_tgt_o == 4'b1011, "R5 helper squash masked", 32'(squash_tgt_o), 32'hb);
        cyc();
        set_idle(); miss(1, ADDR_A, 1); cyc();
        chk(clone_valid_o == 0, "R8 second miss ignored", 32'(clone_valid_o), 0);
        set_idle(); set_rank(0, 7); cyc();
        chk(kill_o == 4'b0100, "R6 rank lost", 32'(kill_o), 32'h4);
        set_rank(0, 1);
        set_idle(); miss(1, ADDR_A, 1); cyc();
        set_idle(); finish_i = 4'b0100; #1;
        chk(done_o == 4'b0000, "R10 helper finish hidden", 32'(done_o), 0);
        cyc();
        chk(kill_o == 4'b0100, "R7 helper finish", 32'(kill_o), 32'h4);
        set_idle(); miss(1, ADDR_A, 1); cyc();
        set_idle(); except_i = 4'b0100; cyc();
        chk(kill_o == 4'b0100, "R7 helper exception", 32'(kill_o), 32'h4);
        set_idle(); miss(1, ADDR_A, 1); cyc();
        set_idle(); finish_i = 4'b0100; miss(1, ADDR_A, 1); cyc();
        chk(kill_o == 4'b0100 && clone_valid_o == 0, "R9 kill first",
            {clone_valid_o, 3'b0, kill_o}, 32'h04);
        set_idle(); cyc();
        chk(clone_valid_o && clone_src_o == 1 && clone_dst_o == 2, "R9 deferred clone",
            {clone_valid_o, 2'b0, clone_src_o, 2'b0, clone_dst_o}, 32'h112);
        set_idle(); finish_i = 4'b0010; cyc();
        chk(kill_o == 4'b0100, "R7 parent finish", 32'(kill_o), 32'h4);
        proc_busy_i = 4'b1111;
        set_idle(); miss(1, ADDR_A, 1); cyc();
        chk(clone_valid_o == 0, "R3 no free processor", 32'(clone_valid_o), 0);
        proc_busy_i = 4'b1011;
        for (int i = 0; i < NP; i++) set_rank(i, 3);
        set_idle(); miss(1, ADDR_A, 1); cyc();
        chk(clone_valid_o == 0, "R4 tie loses", 32'(clone_valid_o), 0);
        set_idle(); miss(0, ADDR_A, 1); cyc();
        chk(clone_valid_o && clone_src_o == 0 && clone_dst_o == 2, "R4 tie wins",
            {clone_valid_o, 2'b0, clone_src_o, 2'b0, clone_dst_o}, 32'h102);

        // Random traffic against the model
        for (int n = 0; n < 4000; n++) begin
            int t;
            set_idle();
            for (int i = 0; i < NP; i++) begin
                if ($urandom_range(0, 9) == 0) proc_busy_i[i] = ($urandom_range(0, 3) != 0);
                if ($urandom_range(0, 19) == 0) set_rank(i, int'($urandom_range(0, 7)));
                finish_i[i] = ($urandom_range(0, 39) == 0);
                except_i[i] = ($urandom_range(0, 59) == 0);
            end
            squash_tgt_i = 4'($urandom); squash_src_i = 4'($urandom);
            t = m_top();
            if ($urandom_range(0, 1) == 1)
                miss(($urandom_range(0, 9) < 7 && t >= 0) ? t : int'($urandom_range(0, 3)),
                     32'(pool[$urandom_range(0, 3)]), $urandom_range(0, 9) < 8);
            if ($urandom_range(0, 1) == 1) begin
                conf_upd_valid_i = 1;
                conf_upd_addr_i = 32'(pool[$urandom_range(0, 3)]);
                conf_upd_hit_i = ($urandom_range(0, 19) < 17);
            end
            cyc();
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    // Watchdog
    initial begin
        #2000000;
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule